// File: doc/BRIEF.md
# Packet-Committing Slave Write FIFO

This block sits on the device side of a synchronous slave write interface. An external master drives a chip select, a write strobe, a two-bit endpoint address, a data word and a packet-end strobe, all sampled on the rising edge of the interface clock. Each of four endpoint FIFOs stores the accepted words and groups them into packets. A packet is released to the downstream consumer in one of two ways. In automatic mode it is released as soon as its word count reaches a programmed length. In manual mode it is released as a short packet when packet-end is sampled.

Each release produces a one-cycle commit event that gives the endpoint, the packet length and whether the commit was automatic. Committed words can then be popped from any endpoint through a simple read port. Per-endpoint full, empty and ready flags follow the stored counts. A write to a full endpoint is dropped and reported with a pulse. A packet-end that lands on the same edge as an automatic commit of that endpoint breaks the interface's spacing rule. It is ignored and recorded in a sticky error bit.

Top module: `slv_pkt_fifo`

## Requirements
- R1: A word is stored only on a rising edge where both slv_cs and slv_wr are 1. Any other combination leaves the stored words and the flags unchanged.
- R2: With both strobes held high, one word is accepted on every edge (burst). Words are read back in the order in which they were written.
- R3: The flags for endpoint i are ep_empty[i], ep_full[i] and ep_ready[i]. ep_empty[i] is 1 when the endpoint holds no words. ep_full[i] is 1 when it holds DEPTH words. ep_ready[i] is 1 when it holds committed words that have not been read. All three reflect a write on the cycle after the edge that performs it.
- R4: An edge with slv_cs=1 and slv_pktend=1 commits every uncommitted word of the addressed endpoint, including a word accepted on that same edge. On the next cycle commit_vld=1, commit_auto=0, commit_ep=address and commit_len=count. With nothing pending, the commit has commit_len=0.
- R5: With auto_en=1 and auto_len in 1..DEPTH, an accepted write that brings the pending count to auto_len commits the packet. On the next cycle commit_vld=1, commit_auto=1 and commit_len=auto_len.
- R6: A packet-end sampled on the same edge as an automatic commit of the addressed endpoint is ignored, and pe_err is set until reset. A packet-end one or more edges later is a valid manual commit.
- R7: A write strobe to an endpoint holding DEPTH words stores nothing. wr_drop is 1 for one cycle after that edge.
- R8: Each of the four endpoints, selected by slv_addr, keeps its own pointers, counts and flags. Activity on one endpoint leaves the others unchanged.
- R9: When rd_en=1 and ep_ready[rd_ep]=1, the oldest committed word of endpoint rd_ep is popped, with rd_vld=1 and rd_data on the next cycle. When rd_en=1 but that endpoint has no committed words, the read is ignored and rd_vld=0.
- R10: After reset every endpoint is empty, not full and not ready, and commit_vld, wr_drop, rd_vld and pe_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| slv_cs | input | 1 | Chip select |
| slv_wr | input | 1 | Write strobe |
| slv_addr | input | 2 | Endpoint select |
| slv_data | input | WIDTH | Write data |
| slv_pktend | input | 1 | Packet-end strobe |
| auto_en | input | 1 | Enable automatic commit |
| auto_len | input | CW | Automatic packet length (1..DEPTH) |
| rd_ep | input | 2 | Endpoint to read |
| rd_en | input | 1 | Pop one committed word |
| rd_vld | output | 1 | rd_data holds a popped word |
| rd_data | output | WIDTH | Popped word |
| commit_vld | output | 1 | Commit event pulse |
| commit_ep | output | 2 | Endpoint of the commit |
| commit_len | output | CW | Words in the committed packet |
| commit_auto | output | 1 | Commit came from the length match |
| wr_drop | output | 1 | Write dropped on a full endpoint |
| pe_err | output | 1 | Sticky: a packet-end broke the spacing rule |
| ep_full | output | 4 | Per-endpoint full flag |
| ep_empty | output | 4 | Per-endpoint empty flag |
| ep_ready | output | 4 | Per-endpoint committed data available |

## Verification
The assertions assume that auto_en and auto_len change only while no endpoint has pending words. They also assume that auto_len stays within 1..DEPTH, because the automatic-length property compares the commit length with the value on the previous edge. The stimulus programs the automatic settings once, during an idle stretch, before any automatic traffic starts. All strobes are driven at the falling edge so that every sampled value is steady around the rising edge.

// File: rtl/slvfifo_pkg.sv
package slvfifo_pkg;

  typedef enum logic [1:0] {
    CMT_NONE   = 2'd0,
    CMT_MANUAL = 2'd1,
    CMT_AUTO   = 2'd2
  } cmt_kind_e;

endpackage

// File: rtl/slv_ep_fifo.sv
module slv_ep_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             commit_en,
  input  logic             rd_en,
  output logic [CW-1:0]    level,
  output logic [CW-1:0]    committed,
  output logic [WIDTH-1:0] rd_data
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr;
  logic [AW-1:0]    rptr;
  logic [CW-1:0]    level_nxt;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    if (p == AW'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  // storage: synchronous write, registered read
  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_data;
    if (rd_en) rd_data <= mem[rptr];
  end

  assign level_nxt = level + CW'(wr_en) - CW'(rd_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr      <= '0;
      rptr      <= '0;
      level     <= '0;
      committed <= '0;
    end else begin
      if (wr_en) wptr <= bump(wptr);
      if (rd_en) rptr <= bump(rptr);
      level <= level_nxt;
      // a commit makes every stored word, this edge's word included, committed
      if (commit_en) committed <= level_nxt;
      else           committed <= committed - CW'(rd_en);
    end
  end

endmodule

// File: rtl/slv_wr_ctrl.sv
module slv_wr_ctrl
  import slvfifo_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int DEPTH  = 16,
  localparam int EPW = $clog2(NUM_EP),
  localparam int CW  = $clog2(DEPTH) + 1
) (
  input  logic                     cs,
  input  logic                     wr,
  input  logic                     pktend,
  input  logic [EPW-1:0]           addr,
  input  logic                     auto_en,
  input  logic [CW-1:0]            auto_len,
  input  logic [NUM_EP-1:0][CW-1:0] level,
  input  logic [NUM_EP-1:0][CW-1:0] committed,
  output logic [NUM_EP-1:0]        wr_acc,
  output logic [NUM_EP-1:0]        commit,
  output cmt_kind_e                kind,
  output logic [CW-1:0]            pkt_len,
  output logic                     drop,
  output logic                     early_pe
);

  logic          strobe;
  logic          sel_full;
  logic          acc;
  logic          auto_hit;
  logic [CW-1:0] pending;

  assign strobe   = cs & wr;
  assign sel_full = (level[addr] == CW'(DEPTH));
  assign acc      = strobe & ~sel_full;
  assign drop     = strobe & sel_full;
  assign pending  = level[addr] - committed[addr];
  assign pkt_len  = pending + CW'(acc);
  assign auto_hit = auto_en & acc & (pkt_len == auto_len);
  assign early_pe = cs & pktend & auto_hit;

  always_comb begin
    if (auto_hit)           kind = CMT_AUTO;
    else if (cs && pktend)  kind = CMT_MANUAL;
    else                    kind = CMT_NONE;
  end

  for (genvar e = 0; e < NUM_EP; e++) begin : g_dec
    assign wr_acc[e] = acc && (addr == EPW'(e));
    assign commit[e] = (kind != CMT_NONE) && (addr == EPW'(e));
  end

endmodule

// File: rtl/slv_pkt_fifo.sv
module slv_pkt_fifo
  import slvfifo_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int DEPTH  = 16,
  parameter int NUM_EP = 4,
  localparam int EPW = $clog2(NUM_EP),
  localparam int CW  = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slv_cs,
  input  logic              slv_wr,
  input  logic [EPW-1:0]    slv_addr,
  input  logic [WIDTH-1:0]  slv_data,
  input  logic              slv_pktend,
  input  logic              auto_en,
  input  logic [CW-1:0]     auto_len,
  input  logic [EPW-1:0]    rd_ep,
  input  logic              rd_en,
  output logic              rd_vld,
  output logic [WIDTH-1:0]  rd_data,
  output logic              commit_vld,
  output logic [EPW-1:0]    commit_ep,
  output logic [CW-1:0]     commit_len,
  output logic              commit_auto,
  output logic              wr_drop,
  output logic              pe_err,
  output logic [NUM_EP-1:0] ep_full,
  output logic [NUM_EP-1:0] ep_empty,
  output logic [NUM_EP-1:0] ep_ready
);

  logic [NUM_EP-1:0][CW-1:0]    level;
  logic [NUM_EP-1:0][CW-1:0]    committed;
  logic [NUM_EP-1:0][WIDTH-1:0] ep_rdata;
  logic [NUM_EP-1:0]            wr_acc;
  logic [NUM_EP-1:0]            commit;
  logic [NUM_EP-1:0]            pop;
  cmt_kind_e                    kind;
  logic [CW-1:0]                pkt_len;
  logic                         drop;
  logic                         early_pe;
  logic [EPW-1:0]               rd_sel_q;

  slv_wr_ctrl #(.NUM_EP(NUM_EP), .DEPTH(DEPTH)) u_ctrl (
    .cs        (slv_cs),
    .wr        (slv_wr),
    .pktend    (slv_pktend),
    .addr      (slv_addr),
    .auto_en   (auto_en),
    .auto_len  (auto_len),
    .level     (level),
    .committed (committed),
    .wr_acc    (wr_acc),
    .commit    (commit),
    .kind      (kind),
    .pkt_len   (pkt_len),
    .drop      (drop),
    .early_pe  (early_pe)
  );

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    assign pop[e] = rd_en && (rd_ep == EPW'(e)) && (committed[e] != '0);

    slv_ep_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (wr_acc[e]),
      .wr_data   (slv_data),
      .commit_en (commit[e]),
      .rd_en     (pop[e]),
      .level     (level[e]),
      .committed (committed[e]),
      .rd_data   (ep_rdata[e])
    );

    assign ep_full[e]  = (level[e] == CW'(DEPTH));
    assign ep_empty[e] = (level[e] == '0);
    assign ep_ready[e] = (committed[e] != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      commit_vld  <= 1'b0;
      commit_ep   <= '0;
      commit_len  <= '0;
      commit_auto <= 1'b0;
      wr_drop     <= 1'b0;
      pe_err      <= 1'b0;
      rd_vld      <= 1'b0;
      rd_sel_q    <= '0;
    end else begin
      commit_vld  <= (kind != CMT_NONE);
      commit_ep   <= slv_addr;
      commit_len  <= pkt_len;
      commit_auto <= (kind == CMT_AUTO);
      wr_drop     <= drop;
      pe_err      <= pe_err | early_pe;
      rd_vld      <= |pop;
      rd_sel_q    <= rd_ep;
    end
  end

  assign rd_data = ep_rdata[rd_sel_q];

endmodule

// File: rtl/slv_pkt_fifo_chk.sv
module slv_pkt_fifo_chk #(
  parameter int WIDTH  = 8,
  parameter int DEPTH  = 16,
  parameter int NUM_EP = 4,
  localparam int EPW = $clog2(NUM_EP),
  localparam int CW  = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              slv_cs,
  input logic              slv_wr,
  input logic [EPW-1:0]    slv_addr,
  input logic              slv_pktend,
  input logic [CW-1:0]     auto_len,
  input logic [EPW-1:0]    rd_ep,
  input logic              rd_en,
  input logic              rd_vld,
  input logic              commit_vld,
  input logic [CW-1:0]     commit_len,
  input logic              commit_auto,
  input logic              wr_drop,
  input logic              pe_err,
  input logic [NUM_EP-1:0] ep_full,
  input logic [NUM_EP-1:0] ep_empty,
  input logic [NUM_EP-1:0] ep_ready
);

  AST_IDLE_FLAGS_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!(slv_cs && slv_wr) && !rd_en) |=> ($stable(ep_empty) && $stable(ep_full))); // R1

  AST_PKTEND_COMMITS: assert property (@(posedge clk) disable iff (rst)
    (slv_cs && slv_pktend && !slv_wr) |=> (commit_vld && !commit_auto)); // R4

  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (rst)
    commit_vld |-> (commit_len <= CW'(DEPTH))); // R4

  AST_AUTO_LEN: assert property (@(posedge clk) disable iff (rst)
    (commit_vld && commit_auto) |-> (commit_len == $past(auto_len))); // R5

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    pe_err |=> pe_err); // R6

  AST_DROP_ON_FULL: assert property (@(posedge clk) disable iff (rst)
    (slv_cs && slv_wr && ep_full[slv_addr]) |=> wr_drop); // R7

  AST_RD_WHEN_READY: assert property (@(posedge clk) disable iff (rst)
    (rd_en && ep_ready[rd_ep]) |=> rd_vld); // R9

  AST_NO_RD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_vld); // R9

endmodule

bind slv_pkt_fifo slv_pkt_fifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH), .NUM_EP(NUM_EP)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .slv_cs      (slv_cs),
  .slv_wr      (slv_wr),
  .slv_addr    (slv_addr),
  .slv_pktend  (slv_pktend),
  .auto_len    (auto_len),
  .rd_ep       (rd_ep),
  .rd_en       (rd_en),
  .rd_vld      (rd_vld),
  .commit_vld  (commit_vld),
  .commit_len  (commit_len),
  .commit_auto (commit_auto),
  .wr_drop     (wr_drop),
  .pe_err      (pe_err),
  .ep_full     (ep_full),
  .ep_empty    (ep_empty),
  .ep_ready    (ep_ready)
);

// File: tb/slv_pkt_fifo_bench.sv
`timescale 1ns/1ps
module slv_pkt_fifo_bench;

  localparam int WIDTH = 8;
  localparam int DEPTH = 16;
  localparam int NEP   = 4;
  localparam int CW    = 5;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             slv_cs = 1'b0, slv_wr = 1'b0, slv_pktend = 1'b0;
  logic [1:0]       slv_addr = '0;
  logic [WIDTH-1:0] slv_data = '0;
  logic             auto_en = 1'b0;
  logic [CW-1:0]    auto_len = 5'd3;
  logic [1:0]       rd_ep = '0;
  logic             rd_en = 1'b0;
  logic             rd_vld, commit_vld, commit_auto, wr_drop, pe_err;
  logic [WIDTH-1:0] rd_data;
  logic [1:0]       commit_ep;
  logic [CW-1:0]    commit_len;
  logic [NEP-1:0]   ep_full, ep_empty, ep_ready;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  slv_pkt_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH), .NUM_EP(NEP)) u_slv_pkt_fifo (
    .clk(clk), .rst(rst), .slv_cs(slv_cs), .slv_wr(slv_wr), .slv_addr(slv_addr),
    .slv_data(slv_data), .slv_pktend(slv_pktend), .auto_en(auto_en), .auto_len(auto_len),
    .rd_ep(rd_ep), .rd_en(rd_en), .rd_vld(rd_vld), .rd_data(rd_data),
    .commit_vld(commit_vld), .commit_ep(commit_ep), .commit_len(commit_len),
    .commit_auto(commit_auto), .wr_drop(wr_drop), .pe_err(pe_err),
    .ep_full(ep_full), .ep_empty(ep_empty), .ep_ready(ep_ready)
  );

  // vector: {cs, wr, addr[2], pktend, data[8], exp_commit, exp_len[5], exp_auto}
  localparam int NV = 8;
  localparam logic [19:0] VEC [NV] = '{
    {1'b1, 1'b1, 2'd0, 1'b0, 8'h11, 1'b0, 5'd0, 1'b0},
    {1'b1, 1'b1, 2'd0, 1'b0, 8'h22, 1'b0, 5'd0, 1'b0},
    {1'b1, 1'b1, 2'd0, 1'b1, 8'h33, 1'b1, 5'd3, 1'b0},
    {1'b1, 1'b0, 2'd0, 1'b1, 8'h99, 1'b1, 5'd0, 1'b0},
    {1'b0, 1'b1, 2'd0, 1'b1, 8'h77, 1'b0, 5'd0, 1'b0},
    {1'b1, 1'b1, 2'd1, 1'b0, 8'h44, 1'b0, 5'd0, 1'b0},
    {1'b1, 1'b0, 2'd1, 1'b0, 8'h66, 1'b0, 5'd0, 1'b0},
    {1'b1, 1'b1, 2'd1, 1'b1, 8'h55, 1'b1, 5'd2, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic cs, input logic wr, input logic [1:0] a,
                      input logic [7:0] d, input logic pe,
                      input logic re, input logic [1:0] rep);
    slv_cs = cs; slv_wr = wr; slv_addr = a; slv_data = d; slv_pktend = pe;
    rd_en = re; rd_ep = rep;
    @(posedge clk);
    @(negedge clk);
    slv_cs = 1'b0; slv_wr = 1'b0; slv_pktend = 1'b0; rd_en = 1'b0;
  endtask

  task automatic pop_chk(input logic [1:0] ep, input int exp);
    step(1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 1'b1, ep);
    chk("R9 rd_vld", int'(rd_vld), 1);
    chk("R2 rd_data order", int'(rd_data), exp);
  endtask

  task automatic reset_chk();
    chk("R10 ep_empty", int'(ep_empty), 15);
    chk("R10 ep_full", int'(ep_full), 0);
    chk("R10 ep_ready", int'(ep_ready), 0);
    chk("R10 commit_vld", int'(commit_vld), 0);
    chk("R10 wr_drop", int'(wr_drop), 0);
    chk("R10 pe_err", int'(pe_err), 0);
    chk("R10 rd_vld", int'(rd_vld), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    reset_chk();

    // R1: strobes alone do not write
    step(1'b0, 1'b1, 2'd3, 8'hA5, 1'b0, 1'b0, 2'd0);
    chk("R1 cs low keeps ep3 empty", int'(ep_empty[3]), 1);
    step(1'b1, 1'b0, 2'd3, 8'hA5, 1'b0, 1'b0, 2'd0);
    chk("R1 wr low keeps ep3 empty", int'(ep_empty[3]), 1);
    chk("R1 no commit", int'(commit_vld), 0);

    // vector table: manual commits, R4 and R1
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][19], VEC[i][18], VEC[i][17:16], VEC[i][14:7], VEC[i][15], 1'b0, 2'd0);
      chk("R4 table commit_vld", int'(commit_vld), int'(VEC[i][6]));
      if (VEC[i][6]) begin
        chk("R4 table commit_len", int'(commit_len), int'(VEC[i][5:1]));
        chk("R4 table commit_auto", int'(commit_auto), int'(VEC[i][0]));
        chk("R4 table commit_ep", int'(commit_ep), int'(VEC[i][17:16]));
      end
    end

    // R2/R9 read back
    chk("R3 ep_ready after commits", int'(ep_ready), 3);
    pop_chk(2'd0, 8'h11);
    pop_chk(2'd0, 8'h22);
    pop_chk(2'd0, 8'h33);
    chk("R3 ep0 empty after reads", int'(ep_empty[0]), 1);
    chk("R3 ep0 not ready", int'(ep_ready[0]), 0);
    step(1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 2'd0);
    chk("R9 read of empty ignored", int'(rd_vld), 0);
    pop_chk(2'd1, 8'h44);
    pop_chk(2'd1, 8'h55);

    // R3/R7/R8: fill ep2 in a burst
    chk("R3 ep2 empty before write", int'(ep_empty[2]), 1);
    for (int i = 0; i < DEPTH; i++) begin
      step(1'b1, 1'b1, 2'd2, 8'(8'h80 + i), 1'b0, 1'b0, 2'd0);
      if (i == 0)         chk("R3 ep2 not empty after first edge", int'(ep_empty[2]), 0);
      if (i == DEPTH - 2) chk("R3 ep2 not full one short", int'(ep_full[2]), 0);
    end
    chk("R3 ep2 full", int'(ep_full[2]), 1);
    chk("R8 only ep2 full", int'(ep_full), 4);
    chk("R8 other endpoints empty", int'(ep_empty), 11);
    step(1'b1, 1'b1, 2'd2, 8'hEE, 1'b0, 1'b0, 2'd0);
    chk("R7 wr_drop pulse", int'(wr_drop), 1);
    step(1'b1, 1'b0, 2'd2, 8'h00, 1'b1, 1'b0, 2'd0);
    chk("R7 wr_drop cleared", int'(wr_drop), 0);
    chk("R7 dropped word not counted", int'(commit_len), DEPTH);
    for (int i = 0; i < DEPTH; i++) pop_chk(2'd2, 8'h80 + i);
    chk("R7 ep2 empty after drain", int'(ep_empty[2]), 1);

    // R5/R6: automatic commits on ep3
    auto_en = 1'b1;
    auto_len = 5'd3;
    step(1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 2'd0);
    step(1'b1, 1'b1, 2'd3, 8'hC0, 1'b0, 1'b0, 2'd0);
    step(1'b1, 1'b1, 2'd3, 8'hC1, 1'b0, 1'b0, 2'd0);
    chk("R5 no commit before length", int'(commit_vld), 0);
    step(1'b1, 1'b1, 2'd3, 8'hC2, 1'b0, 1'b0, 2'd0);
    chk("R5 auto commit_vld", int'(commit_vld), 1);
    chk("R5 auto commit_auto", int'(commit_auto), 1);
    chk("R5 auto commit_len", int'(commit_len), 3);
    chk("R5 auto commit_ep", int'(commit_ep), 3);
    step(1'b1, 1'b1, 2'd3, 8'hC3, 1'b0, 1'b0, 2'd0);
    step(1'b1, 1'b1, 2'd3, 8'hC4, 1'b0, 1'b0, 2'd0);
    chk("R6 pe_err clear before violation", int'(pe_err), 0);
    step(1'b1, 1'b1, 2'd3, 8'hC5, 1'b1, 1'b0, 2'd0);
    chk("R6 same-edge pktend leaves auto commit", int'(commit_auto), 1);
    chk("R6 auto len kept", int'(commit_len), 3);
    chk("R6 pe_err set", int'(pe_err), 1);
    step(1'b1, 1'b0, 2'd3, 8'h00, 1'b1, 1'b0, 2'd0);
    chk("R6 later pktend commits", int'(commit_vld), 1);
    chk("R6 later pktend manual", int'(commit_auto), 0);
    chk("R4 zero-length commit", int'(commit_len), 0);
    step(1'b1, 1'b1, 2'd3, 8'hC6, 1'b1, 1'b0, 2'd0);
    chk("R4 short packet with same-edge word", int'(commit_len), 1);
    chk("R6 pe_err sticky", int'(pe_err), 1);
    pop_chk(2'd3, 8'hC0);

    // R10: reset again
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    reset_chk();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule